// File: doc/BRIEF.md
# Constant Divider by Reciprocal Multiplication

This block divides a stream of unsigned N-bit dividends by one divisor that is loaded beforehand. At run time it never divides. Each dividend is multiplied by a precomputed fixed-point reciprocal. The upper half of the product is kept, and a right shift gives the exact floor quotient. A configuration request loads a new divisor. For an ordinary divisor, an internal restoring divider spends a number of cycles computing 2^(N+L)/d, where L = ceil(log2 d). From that quotient and remainder the block picks one of two multipliers: an N-bit multiplier with post-shift L-1 when its rounding error is small enough, or else the low N bits of an (N+1)-bit multiplier, applied with a subtract/halve/add correction.

Two kinds of divisor need no reciprocal and take effect at once. A power of two becomes a plain right shift. A divisor above 2^(N-1) becomes a single compare, because the quotient can only be 0 or 1. A divisor of zero raises an error flag and holds off all dividends until a nonzero divisor is loaded.

Dividends enter on a valid/ready interface and quotients leave on another one. A beat moves on a cycle where both valid and ready are high. The three internal stages advance together, and they freeze whenever a quotient is waiting and the consumer holds `out_ready` low. `in_ready` is therefore low while the output is stalled, during a reciprocal computation, while the error flag is set, and in any cycle where `cfg_valid` is high. A configuration request is taken only when `busy` is low and no quotient is still inside the block. Otherwise the request is dropped. The control and status pins (`cfg_valid`, `cfg_divisor`, `busy`, `cfg_err`, `wide_mult`) are plain signals.

Top module: `recip_divider`

## Requirements
- R1: After reset `busy`, `cfg_err`, `wide_mult` and `out_valid` are 0, `in_ready` is 1, and the block divides by one, so each quotient equals its dividend.
- R2: For every nonzero loaded divisor d and every dividend n, the quotient delivered is floor(n/d).
- R3: A power-of-two divisor 2^k, including 1, takes effect without `busy` rising, and each quotient is n >> k.
- R4: A divisor above 2^(N-1) that is not a power of two takes effect without `busy` rising, and each quotient is 1 when n >= d and 0 otherwise.
- R5: Any other nonzero divisor raises `busy` in the cycle after the request is taken. `busy` stays high for exactly N+L+1 cycles, with L = ceil(log2 d). `in_ready` is 0 whenever `busy` is 1.
- R6: Once the configuration settles, `wide_mult` is 1 exactly when d is neither a power of two nor above 2^(N-1) and, with P = 2^(N+L-1) and m = ceil(P/d), the excess m*d - P is greater than 2^(L-1). Otherwise it is 0.
- R7: Loading a divisor of 0 sets `cfg_err`. While `cfg_err` is 1, `in_ready` is 0 and no quotient appears. The next nonzero divisor clears `cfg_err`.
- R8: With `out_ready` held high, a dividend accepted on clock edge E produces its quotient with `out_valid` high after edge E+2, the third edge counted from E. One dividend is accepted every cycle.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_quotient` hold their values. Quotients leave in the order their dividends arrived, with none lost or repeated.
- R10: `in_ready` is 0 while `cfg_valid` is 1. A configuration request made while `busy` is 1, or while any quotient is still inside the block, is ignored, and the previous divisor stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Request to load `cfg_divisor` |
| cfg_divisor | input | N | New constant divisor |
| busy | output | 1 | Reciprocal computation in progress |
| cfg_err | output | 1 | Loaded divisor is zero |
| wide_mult | output | 1 | Loaded divisor uses the (N+1)-bit multiplier form |
| in_valid | input | 1 | Dividend present |
| in_ready | output | 1 | Dividend can be taken this cycle |
| in_dividend | input | N | Unsigned dividend |
| out_valid | output | 1 | Quotient present |
| out_ready | input | 1 | Consumer takes the quotient this cycle |
| out_quotient | output | N | floor(dividend / divisor) |

## Verification
The bench uses an 8-bit instance. Every divisor from 0 to 255 is loaded in turn, and all 256 dividends are streamed through each one and compared with integer division. This single sweep covers every path and tells them apart: shift for powers of two, compare for the top half, narrow multiply, and wide multiply with correction. Both multiply forms are also hit by dividends near every multiple of d, where a multiplier off by one would fail. On a quarter of the divisors the consumer withdraws `out_ready` in a repeating pattern, which separates correct stall and ordering from simple pass-through. Directed sequences cover the measured latency and `busy` length, a zero divisor, and configuration requests dropped during a computation or while a quotient is in flight.

// File: rtl/recip_div_pkg.sv
package recip_div_pkg;

  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'd0,
    MODE_CMP    = 2'd1,
    MODE_NARROW = 2'd2,
    MODE_WIDE   = 2'd3
  } div_mode_e;

  localparam int PIPE_STAGES = 3;

endpackage

// File: rtl/recip_div_iter.sv
// Restoring divider: computes floor(2^(N+L)/d) and its remainder.
// It starts with the leading one of the dividend already in the
// remainder, then shifts in N+L zeros, one per cycle.
module recip_div_iter #(
  parameter int N  = 32,
  parameter int CW = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [N-1:0] dvsr_i,
  input  logic [CW-1:0] steps_i,
  output logic         done_o,
  output logic [N:0]   quo_o,
  output logic [N-1:0] rem_o
);

  logic [N-1:0]  rem_q;
  logic [N:0]    quo_q;
  logic [CW-1:0] cnt_q;
  logic [N-1:0]  dvsr_q;
  logic          done_q;

  logic [N:0]   rem_sh;
  logic         take;
  logic [N-1:0] rem_nx;

  always_comb begin
    rem_sh = {rem_q, 1'b0};
    take   = rem_sh >= {1'b0, dvsr_q};
    rem_nx = take ? N'(rem_sh - {1'b0, dvsr_q}) : N'(rem_sh);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      dvsr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        rem_q  <= N'(1);
        quo_q  <= '0;
        cnt_q  <= steps_i;
        dvsr_q <= dvsr_i;
      end else if (cnt_q != '0) begin
        rem_q <= rem_nx;
        quo_q <= {quo_q[N-1:0], take};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q;
  assign rem_o  = rem_q;

endmodule

// File: rtl/recip_div_cfg.sv
// Divisor classification and selection of the reciprocal form.
module recip_div_cfg
  import recip_div_pkg::*;
#(
  parameter int N   = 32,
  parameter int SHW = 5,
  parameter int CW  = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [N-1:0]   divisor_i,
  input  logic           iter_done_i,
  input  logic [N:0]     iter_quo_i,
  input  logic [N-1:0]   iter_rem_i,
  output logic           iter_load_o,
  output logic [CW-1:0]  iter_steps_o,
  output logic           busy_o,
  output logic           err_o,
  output logic           wide_o,
  output div_mode_e      mode_o,
  output logic [N-1:0]   mult_o,
  output logic [SHW-1:0] shamt_o,
  output logic [N-1:0]   dvsr_o
);

  logic [SHW-1:0] msb;
  logic           is_zero;
  logic           is_pow2;
  logic           is_top;
  logic           is_gen;

  always_comb begin
    msb = '0;
    for (int i = 0; i < N; i++) begin
      if (divisor_i[i]) msb = SHW'(i);
    end
  end

  assign is_zero = (divisor_i == '0);
  assign is_pow2 = !is_zero && ((divisor_i & (divisor_i - 1'b1)) == '0);
  assign is_top  = divisor_i[N-1];
  assign is_gen  = !is_zero && !is_pow2 && !is_top;

  assign iter_load_o  = start_i && is_gen;
  assign iter_steps_o = CW'(N) + CW'(msb) + CW'(1);

  logic           busy_q, err_q, wide_q;
  div_mode_e      mode_q;
  logic [N-1:0]   mult_q;
  logic [SHW-1:0] sh_q;
  logic [SHW-1:0] ell_q;
  logic [N-1:0]   dvsr_q;

  // Narrow candidate from the wide quotient: halve Q and R.
  logic [N-1:0] q_half;
  logic [N-1:0] r_half;
  logic [N-1:0] excess;
  logic [N-1:0] limit;
  logic         narrow_ok;

  always_comb begin
    q_half    = iter_quo_i[N:1];
    r_half    = iter_quo_i[0] ? N'(({1'b0, dvsr_q} + {1'b0, iter_rem_i}) >> 1)
                              : N'(iter_rem_i >> 1);
    excess    = dvsr_q - r_half;
    limit     = N'(1) << (ell_q - 1'b1);
    narrow_ok = excess <= limit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      wide_q <= 1'b0;
      mode_q <= MODE_SHIFT;
      mult_q <= '0;
      sh_q   <= '0;
      ell_q  <= SHW'(1);
      dvsr_q <= N'(1);
    end else if (start_i) begin
      wide_q <= 1'b0;
      if (is_zero) begin
        err_q <= 1'b1;
      end else begin
        err_q  <= 1'b0;
        dvsr_q <= divisor_i;
        if (is_pow2) begin
          mode_q <= MODE_SHIFT;
          sh_q   <= msb;
        end else if (is_top) begin
          mode_q <= MODE_CMP;
          sh_q   <= '0;
        end else begin
          busy_q <= 1'b1;
          ell_q  <= msb + 1'b1;
        end
      end
    end else if (busy_q && iter_done_i) begin
      busy_q <= 1'b0;
      sh_q   <= ell_q - 1'b1;
      if (narrow_ok) begin
        mode_q <= MODE_NARROW;
        mult_q <= q_half + 1'b1;
      end else begin
        mode_q <= MODE_WIDE;
        mult_q <= iter_quo_i[N-1:0] + 1'b1;
        wide_q <= 1'b1;
      end
    end
  end

  assign busy_o  = busy_q;
  assign err_o   = err_q;
  assign wide_o  = wide_q;
  assign mode_o  = mode_q;
  assign mult_o  = mult_q;
  assign shamt_o = sh_q;
  assign dvsr_o  = dvsr_q;

endmodule

// File: rtl/recip_div_pipe.sv
// Three-stage run datapath: multiply-high, correct/select, post-shift.
module recip_div_pipe
  import recip_div_pkg::*;
#(
  parameter int N   = 32,
  parameter int SHW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv_i,
  input  logic           fire_i,
  input  logic [N-1:0]   data_i,
  input  div_mode_e      mode_i,
  input  logic [N-1:0]   mult_i,
  input  logic [SHW-1:0] shamt_i,
  input  logic [N-1:0]   dvsr_i,
  output logic           valid_o,
  output logic [N-1:0]   quot_o,
  output logic           idle_o
);

  logic [PIPE_STAGES-1:0] vld_q;
  logic [N-1:0] n1_q, t1_q, r2_q, q3_q;

  logic [N-1:0] t_nx;
  logic [N-1:0] r_nx;

  assign t_nx = N'(((2*N)'(data_i) * (2*N)'(mult_i)) >> N);

  always_comb begin
    case (mode_i)
      MODE_SHIFT:  r_nx = n1_q;
      MODE_CMP:    r_nx = {{(N-1){1'b0}}, (n1_q >= dvsr_i)};
      MODE_NARROW: r_nx = t1_q;
      default:     r_nx = t1_q + ((n1_q - t1_q) >> 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (adv_i) begin
      vld_q <= {vld_q[PIPE_STAGES-2:0], fire_i};
    end
  end

  always_ff @(posedge clk) begin
    if (adv_i) begin
      n1_q <= data_i;
      t1_q <= t_nx;
      r2_q <= r_nx;
      q3_q <= r2_q >> shamt_i;
    end
  end

  assign valid_o = vld_q[PIPE_STAGES-1];
  assign quot_o  = q3_q;
  assign idle_o  = (vld_q == '0);

endmodule

// File: rtl/recip_divider.sv
module recip_divider
  import recip_div_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_valid,
  input  logic [N-1:0] cfg_divisor,
  output logic         busy,
  output logic         cfg_err,
  output logic         wide_mult,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_dividend,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_quotient
);

  localparam int SHW = (N > 1) ? $clog2(N) : 1;
  localparam int CW  = $clog2(2 * N);

  logic           pipe_idle;
  logic           adv;
  logic           cfg_take;
  logic           in_fire;
  logic           iter_load, iter_done;
  logic [CW-1:0]  iter_steps;
  logic [N:0]     iter_quo;
  logic [N-1:0]   iter_rem;
  div_mode_e      mode;
  logic [N-1:0]   mult;
  logic [SHW-1:0] shamt;
  logic [N-1:0]   dvsr;

  assign adv      = !out_valid || out_ready;
  assign cfg_take = cfg_valid && !busy && pipe_idle;
  assign in_ready = !busy && !cfg_err && adv && !cfg_valid;
  assign in_fire  = in_valid && in_ready;

  recip_div_cfg #(.N(N), .SHW(SHW), .CW(CW)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (cfg_take),
    .divisor_i    (cfg_divisor),
    .iter_done_i  (iter_done),
    .iter_quo_i   (iter_quo),
    .iter_rem_i   (iter_rem),
    .iter_load_o  (iter_load),
    .iter_steps_o (iter_steps),
    .busy_o       (busy),
    .err_o        (cfg_err),
    .wide_o       (wide_mult),
    .mode_o       (mode),
    .mult_o       (mult),
    .shamt_o      (shamt),
    .dvsr_o       (dvsr)
  );

  recip_div_iter #(.N(N), .CW(CW)) u_iter (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (iter_load),
    .dvsr_i  (cfg_divisor),
    .steps_i (iter_steps),
    .done_o  (iter_done),
    .quo_o   (iter_quo),
    .rem_o   (iter_rem)
  );

  recip_div_pipe #(.N(N), .SHW(SHW)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_i   (adv),
    .fire_i  (in_fire),
    .data_i  (in_dividend),
    .mode_i  (mode),
    .mult_i  (mult),
    .shamt_i (shamt),
    .dvsr_i  (dvsr),
    .valid_o (out_valid),
    .quot_o  (out_quotient),
    .idle_o  (pipe_idle)
  );

endmodule

// File: rtl/recip_divider_chk.sv
module recip_divider_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_valid,
  input logic         busy,
  input logic         cfg_err,
  input logic         wide_mult,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [N-1:0] out_quotient
);

  AST_BUSY_GATES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready); // R5

  AST_ERR_GATES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (!in_ready && !out_valid)); // R7

  AST_CFG_GATES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> !in_ready); // R10

  AST_BUSY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !out_valid); // R10

  AST_WIDE_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wide_mult); // R6

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient))); // R9

  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 3) && $past(out_ready, 2) && $past(out_ready))
      |-> out_valid); // R8

endmodule

bind recip_divider recip_divider_chk #(.N(N)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_valid    (cfg_valid),
  .busy         (busy),
  .cfg_err      (cfg_err),
  .wide_mult    (wide_mult),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_quotient (out_quotient)
);

// File: tb/recip_divider_tb.sv
`timescale 1ns/1ps
module recip_divider_tb;

  localparam int N    = 8;
  localparam int MAXV = 1 << N;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cfg_valid;
  logic [N-1:0] cfg_divisor;
  logic         busy, cfg_err, wide_mult;
  logic         in_valid, in_ready;
  logic [N-1:0] in_dividend;
  logic         out_valid, out_ready;
  logic [N-1:0] out_quotient;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  recip_divider #(.N(N)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_valid    (cfg_valid),
    .cfg_divisor  (cfg_divisor),
    .busy         (busy),
    .cfg_err      (cfg_err),
    .wide_mult    (wide_mult),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_dividend  (in_dividend),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_quotient (out_quotient)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int clog2i(input int d);
    int l = 0;
    while ((1 << l) < d) l++;
    return l;
  endfunction

  function automatic bit pow2(input int d);
    return (d != 0) && ((d & (d - 1)) == 0);
  endfunction

  function automatic bit general(input int d);
    return (d != 0) && !pow2(d) && (d < MAXV / 2);
  endfunction

  // R6 rule computed from the requirement text
  function automatic bit exp_wide(input int d);
    int     l;
    longint p, m;
    if (!general(d)) return 1'b0;
    l = clog2i(d);
    p = longint'(1) << (N + l - 1);
    m = (p + d - 1) / d;
    return (m * d - p) > (longint'(1) << (l - 1));
  endfunction

  function automatic string qtag(input int d);
    if (pow2(d))        return "R3";
    if (d > MAXV / 2)   return "R4";
    return "R2";
  endfunction

  task automatic do_cfg(input int d);
    int cnt = 0;
    @(negedge clk);
    cfg_valid   = 1'b1;
    cfg_divisor = d[N-1:0];
    @(negedge clk);
    cfg_valid = 1'b0;
    while (busy && cnt < 4 * N) begin
      cnt++;
      @(negedge clk);
    end
    if (general(d)) chk("R5 busy length", cnt, N + clog2i(d) + 1);
    else            chk((d == 0) ? "R7 busy" : (pow2(d) ? "R3 busy" : "R4 busy"), cnt, 0);
    chk("R7 err flag", cfg_err, (d == 0));
    chk("R6 wide flag", wide_mult, exp_wide(d));
  endtask

  task automatic one_beat(input int n, output int q);
    int lat = 0;
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = n[N-1:0];
    out_ready   = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    q = out_quotient;
  endtask

  task automatic sweep(input int d, input bit bp, input string tag);
    int sent = 0, got = 0, cyc = 0, stalls = 0;
    bit hold = 1'b0;
    logic [N-1:0] hold_val = '0;
    while (got < MAXV && cyc < 4 * MAXV + 64) begin
      @(negedge clk);
      out_ready   = bp ? ((cyc % 3) != 1) : 1'b1;
      in_valid    = (sent < MAXV);
      in_dividend = sent[N-1:0];
      cyc++;
      #1;
      if (hold) begin
        chk("R9 hold valid", out_valid, 1);
        chk("R9 hold data", out_quotient, hold_val);
      end
      hold = 1'b0;
      if (out_valid) begin
        if (out_ready) begin
          chk(tag, out_quotient, got / d);
          got++;
        end else begin
          hold     = 1'b1;
          hold_val = out_quotient;
        end
      end
      if (in_valid && !in_ready) stalls++;
      if (in_valid && in_ready) sent++;
    end
    chk("R9 count", got, MAXV);
    if (!bp) chk("R8 throughput stalls", stalls, 0);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R8 watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int q, lat;
    rst_n       = 1'b0;
    cfg_valid   = 1'b0;
    cfg_divisor = '0;
    in_valid    = 1'b0;
    in_dividend = '0;
    out_ready   = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 busy", busy, 0);
    chk("R1 err", cfg_err, 0);
    chk("R1 wide", wide_mult, 0);
    chk("R1 out_valid", out_valid, 0);
    chk("R1 in_ready", in_ready, 1);
    sweep(1, 1'b0, "R1 divide by one");

    // R8: measured latency with the consumer always ready
    do_cfg(7);
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = 8'd100;
    out_ready   = 1'b1;
    #1;
    chk("R8 ready", in_ready, 1);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    chk("R8 latency", lat, 3);
    chk("R2 quotient 100/7", out_quotient, 14);

    // R10: cfg_valid alone drops in_ready
    @(negedge clk);
    cfg_valid   = 1'b1;
    cfg_divisor = 8'd5;
    in_valid    = 1'b1;
    #1;
    chk("R10 in_ready during cfg", in_ready, 0);
    @(negedge clk);
    cfg_valid = 1'b0;
    in_valid  = 1'b0;
    while (busy) @(negedge clk);
    one_beat(99, q);
    chk("R2 quotient 99/5", q, 19);

    // R10: request during busy is dropped
    @(negedge clk);
    cfg_valid   = 1'b1;
    cfg_divisor = 8'd7;
    @(negedge clk);
    cfg_divisor = 8'd9;
    #1;
    chk("R10 busy during retry", busy, 1);
    @(negedge clk);
    cfg_valid = 1'b0;
    while (busy) @(negedge clk);
    one_beat(63, q);
    chk("R10 kept divisor 7", q, 9);

    // R10: request while a quotient is in flight is dropped
    @(negedge clk);
    in_valid    = 1'b1;
    in_dividend = 8'd50;
    out_ready   = 1'b1;
    @(negedge clk);
    in_valid    = 1'b0;
    cfg_valid   = 1'b1;
    cfg_divisor = 8'd3;
    @(negedge clk);
    cfg_valid = 1'b0;
    #1;
    chk("R10 no busy in flight", busy, 0);
    while (!out_valid) @(negedge clk);
    chk("R10 in-flight quotient", out_quotient, 7);
    @(negedge clk);
    one_beat(50, q);
    chk("R10 divisor unchanged", q, 7);

    // R7: zero divisor blocks input until a valid divisor is loaded
    do_cfg(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_valid    = 1'b1;
      in_dividend = 8'd12;
      #1;
      chk("R7 in_ready blocked", in_ready, 0);
      chk("R7 no output", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0;

    // Exhaustive divisor and dividend sweep
    for (int d = 1; d < MAXV; d++) begin
      do_cfg(d);
      sweep(d, (d % 4) == 3, qtag(d));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule